// File: doc/BRIEF.md
# Time-Multiplexed Multiported Register File

This block stands in for a register file with three read ports and two write ports. It does so without a flip-flop array with that many ports. It keeps one copy of the register contents for each read port, in memories that allow one read and one write per host clock. The work of one target clock cycle is then spread over three host clocks.

A caller presents the read addresses and the two write requests for one target cycle and pulses `start`. In the first host cycle every copy is read, one copy per read port. In the second host cycle write port 0 updates every copy, and in the third host cycle write port 1 does the same. Because write port 1 lands last, it wins when both ports name the same register. Reads always see the contents from before the current target cycle's writes, which is how a register file behaves when it writes at the end of the cycle.

`done` marks the third host cycle. A new `start` may arrive in that cycle, so target cycles can follow each other with no gap. The host cycle count per target cycle is derived from the number of write ports. The behaviour seen per target cycle does not depend on it.

Top module: `mp_regfile_tm`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `done` is 0 and every `rdData` lane is 0.
- R2: A `start` sampled high at a clock edge while the block is idle is accepted. `done` is then high for exactly one host cycle, the third host cycle after that edge, and low otherwise.
- R3: Each read port p returns the register named by `rdAddr[p]`, as that register stood when the target cycle was accepted. The value appears from the second host cycle after acceptance and is held until the read step of the next accepted target cycle.
- R4: A read of a register that the same target cycle also writes returns the old value. The new value is seen from the next target cycle on.
- R5: A write updates the register for every read port. All three ports reading the same register return the same value.
- R6: When both write ports are enabled for the same register in one target cycle, the value from write port 1 (lane index 1) is kept.
- R7: A write port whose `wrEn` bit is 0 leaves every register unchanged.
- R8: A `start` sampled in the first or second host cycle of a target cycle in progress is ignored, together with its request.
- R9: A `start` sampled in the `done` cycle is accepted at once. Its reads see the writes of the target cycle that is just ending.
- R10: Requests are captured only at the accepting edge. Later changes to the request inputs have no effect on the target cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a target cycle with the request on the inputs |
| rdAddr | input | 3x5 | Read address for each read port, lane p = port p |
| wrEn | input | 2 | Write enable for each write port |
| wrAddr | input | 2x5 | Write address for each write port |
| wrData | input | 2x32 | Write data for each write port |
| rdData | output | 3x32 | Read result for each read port |
| done | output | 1 | High in the last host cycle of a target cycle |

## Verification
Counted from the edge that accepts `start`, the read results change at the next edge and are due from the second host cycle on. `done` rises after the second edge and falls after the third. The bench model advances one step per edge. It takes the reads at the step that ends the first host cycle and applies both writes, port 0 then port 1, at the step that ends the third. Outputs are compared at every falling edge, half a period after the edge that changed them. Read lanes whose register has never been written are skipped.

// File: rtl/mp_regfile_tm_pkg.sv
package mp_regfile_tm_pkg;

  // widest write-port selector carried in the strobe struct
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             latch;  // capture the request on this edge
    logic             rdEn;   // read every bank on this edge
    logic             wrEn;   // write step active on this edge
    logic [SEL_W-1:0] wrSel;  // which write port this step serves
    logic             done;   // last host cycle of the target cycle
  } ctlT;

endpackage

// File: rtl/mp_regfile_tm_ctl.sv
module mp_regfile_tm_ctl
  import mp_regfile_tm_pkg::*;
#(
  parameter int NUM_WR = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctlT  ctl
);

  localparam int HOST_CYC = NUM_WR + 1;
  localparam int PH_W     = $clog2(HOST_CYC);
  localparam logic [PH_W-1:0] LAST = PH_W'(HOST_CYC - 1);

  logic            active;
  logic [PH_W-1:0] phase;
  logic            accept;

  assign accept = start && (!active || phase == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      phase  <= '0;
    end else if (active) begin
      if (phase == LAST) begin
        active <= 1'b0;
        phase  <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.latch = accept;
    ctl.rdEn  = active && (phase == '0);
    ctl.wrEn  = active && (phase != '0);
    ctl.wrSel = SEL_W'(phase) - SEL_W'(1);
    ctl.done  = active && (phase == LAST);
  end

  AST_READ_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latch |=> ctl.rdEn); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !ctl.done); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && active && phase != LAST) |=> (phase != '0)); // R8

endmodule

// File: rtl/mp_regfile_tm_dp.sv
module mp_regfile_tm_dp
  import mp_regfile_tm_pkg::*;
#(
  parameter int NUM_RD = 3,
  parameter int NUM_WR = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlT                           ctl,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  input  logic [NUM_WR-1:0]             wrEn,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] wrAddr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int WI_W  = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddrQ;
  logic [NUM_WR-1:0]             wrEnQ;
  logic [NUM_WR-1:0][ADDR_W-1:0] wrAddrQ;
  logic [NUM_WR-1:0][DATA_W-1:0] wrDataQ;

  logic [WI_W-1:0]   wrIdx;
  logic              wrGo;
  logic [ADDR_W-1:0] wrAddrSel;
  logic [DATA_W-1:0] wrDataSel;

  // request capture at the accepting edge only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      wrEnQ   <= '0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else if (ctl.latch) begin
      rdAddrQ <= rdAddr;
      wrEnQ   <= wrEn;
      wrAddrQ <= wrAddr;
      wrDataQ <= wrData;
    end
  end

  assign wrIdx     = ctl.wrSel[WI_W-1:0];
  assign wrGo      = ctl.wrEn && wrEnQ[wrIdx];
  assign wrAddrSel = wrAddrQ[wrIdx];
  assign wrDataSel = wrDataQ[wrIdx];

  // one replicated one-read/one-write bank per read port
  for (genvar g = 0; g < NUM_RD; g++) begin : gBank
    logic [DATA_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wrGo) bank[wrAddrSel] <= wrDataSel;
    end

    always_ff @(posedge clk) begin
      if (!rstN)         rdData[g] <= '0;
      else if (ctl.rdEn) rdData[g] <= bank[rdAddrQ[g]];
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> $stable(rdData)); // R3

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdEn |-> !ctl.wrEn); // R4

endmodule

// File: rtl/mp_regfile_tm.sv
module mp_regfile_tm
  import mp_regfile_tm_pkg::*;
#(
  parameter int NUM_RD = 3,
  parameter int NUM_WR = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  input  logic [NUM_WR-1:0]             wrEn,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] wrAddr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wrData,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic                          done
);

  ctlT ctl;

  mp_regfile_tm_ctl #(.NUM_WR(NUM_WR)) uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl)
  );

  mp_regfile_tm_dp #(
    .NUM_RD (NUM_RD),
    .NUM_WR (NUM_WR),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rdAddr (rdAddr),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign done = ctl.done;

endmodule

// File: tb/sim_mp_regfile_tm.sv
module sim_mp_regfile_tm;

  localparam int NRD = 3;
  localparam int NWR = 2;
  localparam int AW  = 5;
  localparam int DW  = 32;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NRD-1:0][AW-1:0] rdAddr = '0;
  logic [NWR-1:0]         wrEn = '0;
  logic [NWR-1:0][AW-1:0] wrAddr = '0;
  logic [NWR-1:0][DW-1:0] wrData = '0;
  logic [NRD-1:0][DW-1:0] rdData;
  logic done;

  always #10 clk = ~clk; // 50 MHz

  mp_regfile_tm u0 (
    .clk(clk), .rstN(rstN), .start(start), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdData(rdData), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R3";
  bit finished = 1'b0;

  // behavioural reference: register array plus a target-cycle step count
  logic [DW-1:0] refMem [NREG];
  bit            known  [NREG];
  int            mCnt = 0;
  logic [NRD-1:0][AW-1:0] pRd;
  logic [NWR-1:0]         pWe;
  logic [NWR-1:0][AW-1:0] pWa;
  logic [NWR-1:0][DW-1:0] pWd;
  logic [DW-1:0] expRd [NRD];
  bit            expKnown [NRD];

  initial begin
    for (int i = 0; i < NREG; i++) begin refMem[i] = '0; known[i] = 1'b0; end
    for (int p = 0; p < NRD; p++) begin expRd[p] = '0; expKnown[p] = 1'b1; end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      for (int p = 0; p < NRD; p++) begin expRd[p] = '0; expKnown[p] = 1'b1; end
    end else begin
      if (mCnt == 1)
        for (int p = 0; p < NRD; p++) begin
          expRd[p] = refMem[pRd[p]];
          expKnown[p] = known[pRd[p]];
        end
      if (mCnt == 3)
        for (int w = 0; w < NWR; w++)
          if (pWe[w]) begin refMem[pWa[w]] = pWd[w]; known[pWa[w]] = 1'b1; end
      if (start && (mCnt == 0 || mCnt == 3)) begin
        pRd = rdAddr; pWe = wrEn; pWa = wrAddr; pWd = wrData;
        mCnt = 1;
      end else if (mCnt == 3) mCnt = 0;
      else if (mCnt != 0) mCnt = mCnt + 1;
    end
  end

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      if (done !== (mCnt == 3)) begin
        miscompares++;
        $display("FAIL R2 done got %b exp %b", done, (mCnt == 3));
      end
      for (int p = 0; p < NRD; p++)
        if (expKnown[p]) begin
          vectors++;
          if (rdData[p] !== expRd[p]) begin
            miscompares++;
            $display("FAIL %s rdData[%0d] got %h exp %h", curReq, p, rdData[p], expRd[p]);
          end
        end
    end
  end

  task automatic drive(input logic [NRD-1:0][AW-1:0] ra, input logic [NWR-1:0] we,
                       input logic [NWR-1:0][AW-1:0] wa, input logic [NWR-1:0][DW-1:0] wd);
    rdAddr = ra; wrEn = we; wrAddr = wa; wrData = wd;
  endtask

  // called just after a falling edge; returns in the done cycle's falling edge
  task automatic issue(input logic [NRD-1:0][AW-1:0] ra, input logic [NWR-1:0] we,
                       input logic [NWR-1:0][AW-1:0] wa, input logic [NWR-1:0][DW-1:0] wd,
                       input bit garble);
    drive(ra, we, wa, wd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (garble) drive({AW*NRD{1'b1}}, '1, '1, {$urandom, $urandom});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    vectors++;
    if (done !== 1'b0 || rdData !== '0) begin
      miscompares++;
      $display("FAIL R1 reset done=%b rdData=%h exp 0", done, rdData);
    end
    rstN = 1'b1;
    @(negedge clk);
    vectors++;
    if (done !== 1'b0 || rdData !== '0) begin
      miscompares++;
      $display("FAIL R1 after reset done=%b rdData=%h exp 0", done, rdData);
    end

    // R5: fill every register, two per target cycle
    curReq = "R5";
    for (int i = 0; i < NREG; i += 2)
      issue('0, 2'b11, {AW'(i + 1), AW'(i)}, {32'hA500_0000 + i + 1, 32'hA500_0000 + i}, 1'b0);
    issue({AW'(3), AW'(3), AW'(3)}, 2'b00, '0, '0, 1'b0);
    issue({AW'(17), AW'(17), AW'(17)}, 2'b00, '0, '0, 1'b0);

    // R4: read and write the same register in one target cycle
    curReq = "R4";
    issue({AW'(5), AW'(6), AW'(5)}, 2'b11, {AW'(6), AW'(5)}, {32'h6666_0006, 32'h5555_0005}, 1'b0);
    issue({AW'(5), AW'(6), AW'(0)}, 2'b00, '0, '0, 1'b0);

    // R6: both write ports on one register
    curReq = "R6";
    issue('0, 2'b11, {AW'(7), AW'(7)}, {32'hBBBB_0001, 32'hAAAA_0000}, 1'b0);
    issue({AW'(7), AW'(7), AW'(7)}, 2'b00, '0, '0, 1'b0);

    // R7: disabled write ports
    curReq = "R7";
    issue('0, 2'b00, {AW'(9), AW'(10)}, {32'hDEAD_0009, 32'hDEAD_0010}, 1'b0);
    issue('0, 2'b01, {AW'(9), AW'(11)}, {32'hDEAD_1009, 32'h1111_0011}, 1'b0);
    issue({AW'(9), AW'(10), AW'(11)}, 2'b00, '0, '0, 1'b0);

    // R8: start pulses while busy are dropped
    curReq = "R8";
    idle(2);
    drive({AW'(1), AW'(2), AW'(3)}, 2'b01, {AW'(0), AW'(12)}, {32'h0, 32'hC0DE_0012});
    start = 1'b1;
    @(negedge clk);
    drive('0, 2'b11, {AW'(13), AW'(14)}, {32'hBAD0_0013, 32'hBAD0_0014});
    @(negedge clk);
    drive('0, 2'b11, {AW'(15), AW'(16)}, {32'hBAD0_0015, 32'hBAD0_0016});
    @(negedge clk);
    start = 1'b0;
    idle(2);
    issue({AW'(12), AW'(13), AW'(14)}, 2'b00, '0, '0, 1'b0);
    issue({AW'(15), AW'(16), AW'(12)}, 2'b00, '0, '0, 1'b0);

    // R10: inputs change after acceptance
    curReq = "R10";
    issue({AW'(20), AW'(21), AW'(22)}, 2'b11, {AW'(21), AW'(20)}, {32'h2121_2121, 32'h2020_2020}, 1'b1);
    issue({AW'(20), AW'(21), AW'(31)}, 2'b00, '0, '0, 1'b1);

    // R9: back-to-back target cycles, each reading the previous writes
    curReq = "R9";
    for (int k = 0; k < 8; k++)
      issue({AW'(k + 24), AW'(k + 23), AW'(k + 24)}, 2'b11,
            {AW'(k + 25), AW'(k + 24)}, {32'h9000_0000 + k, 32'h9100_0000 + k}, 1'b0);

    // R3: mixed traffic with idle gaps, read data held between target cycles
    curReq = "R3";
    for (int k = 0; k < 60; k++) begin
      issue({AW'($urandom), AW'($urandom), AW'($urandom)}, NWR'($urandom),
            {AW'($urandom), AW'($urandom)}, {$urandom, $urandom}, 1'b0);
      if (k % 3 == 0) idle(k % 5);
    end

    idle(6);
    finish_run();
  end

endmodule